// File: doc/BRIEF.md
# Trace Prefetch Buffer Controller

This block keeps a small, fully associative store of prefetched traces and decides when a predicted future trace is worth fetching from the slow second-level trace store. Each prefetch request carries a trace identifier and the confidence counter that the predictor attached to it. A request with zero confidence does nothing. A confident request is checked against the first-level trace cache (through a probe result that the cache returns in the same cycle) and against the buffer's own tags. If either already holds the trace, the request is cancelled. Otherwise, when the second-level store reports that it holds the trace, a request is sent there. The returned payload is installed as the most recently used entry.

The fetch stage also looks up traces by identifier. The hit flag and the payload come back in the same cycle as the lookup, so the buffer answers as fast as the first-level cache. A demand hit refreshes the entry's recency. Only one second-level request can be outstanding at a time. Four running counters let the accuracy of the prefetcher be measured: issued, demand hits, cancelled, and dropped while busy. Payloads are opaque words.

Top module: `trace_pfb`

## Requirements
- R1: After reset the buffer holds no entries, every demand lookup misses, all four counters read zero and no second-level request is driven.
- R2: A prefetch whose confidence is 0 issues no request and changes no counter.
- R3: A confident prefetch whose identifier is present in the first-level cache (probe input high) or in the buffer is cancelled and increments the cancel counter. Cancellation has priority over the busy drop and over issue.
- R4: A confident prefetch that is not cancelled, arrives with no request outstanding and is reported present by the second-level probe drives the request strobe and identifier in that same cycle and increments the issue counter.
- R5: A request is outstanding from its issue cycle up to and including the cycle in which the response arrives. A confident, non-cancelled prefetch in that window issues nothing and increments the busy-drop counter.
- R6: The response installs the outstanding identifier with the returned payload, unless that identifier is already held, so that no two valid entries share an identifier.
- R7: A demand lookup returns hit and payload combinationally in the cycle of the lookup, counts each hit, and never reports a hit without a valid lookup.
- R8: An install fills a free entry if one exists; otherwise it replaces the least recently used entry. Both demand hits and installs make the entry most recently used.
- R9: When a demand hit and an install fall in the same cycle, the victim is chosen from the recency order at the start of that cycle, the demand sees the old contents, and the installed entry ends up more recent than the demand-hit entry.
- R10: A confident prefetch that is in neither cache and is not reported by the second-level probe does nothing and is not counted.
- R11: A response that arrives with no request outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pf_valid_i | input | 1 | Prefetch request valid |
| pf_id_i | input | ID_W | Identifier of the predicted trace |
| pf_conf_i | input | CONF_W | Confidence counter attached to the prediction |
| l1_hit_i | input | 1 | First-level cache probe result for pf_id_i |
| l2_hit_i | input | 1 | Second-level store probe result for pf_id_i |
| l2_req_o | output | 1 | Second-level fetch strobe |
| l2_req_id_o | output | ID_W | Identifier to fetch |
| l2_rsp_valid_i | input | 1 | Second-level response valid |
| l2_rsp_data_i | input | DATA_W | Returned trace payload |
| dm_valid_i | input | 1 | Demand lookup valid |
| dm_id_i | input | ID_W | Demand lookup identifier |
| dm_hit_o | output | 1 | Demand lookup hit |
| dm_data_o | output | DATA_W | Payload of the hit entry |
| cnt_issue_o | output | STAT_W | Issued prefetch count |
| cnt_hit_o | output | STAT_W | Demand hit count |
| cnt_cancel_o | output | STAT_W | Cancelled prefetch count |
| cnt_busy_o | output | STAT_W | Prefetches dropped while busy |

## Verification
The delicate overlap is a demand lookup that lands in the same cycle as a second-level response install. Both then update the recency order, and the demand may even hit the entry that is about to be evicted. Directed cases put a lookup of the current least recent entry exactly in the response cycle of a full buffer. A long random phase over a pool larger than the buffer makes such overlaps happen often. A behavioural model keeps a recency-ordered list and judges every cycle: the demand must see the pre-install contents, the start-of-cycle victim must disappear, and later evictions must follow the order the model expects.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  typedef enum logic [1:0] {
    PF_NONE,
    PF_CANCEL,
    PF_BUSY,
    PF_ISSUE
  } pf_act_e;
endpackage

// File: rtl/tpb_store.sv
module tpb_store #(
  parameter int N      = 16,
  parameter int ID_W   = 16,
  parameter int DATA_W = 32,
  parameter int NQ     = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [ID_W-1:0]           wr_id_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [NQ-1:0][ID_W-1:0]   q_id_i,
  output logic [NQ-1:0]             q_hit_o,
  output logic [IDX_W-1:0]          rd_idx_o,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic [N-1:0]              valid_o
);
  logic [N-1:0]             valid_q;
  logic [N-1:0][ID_W-1:0]   tag_q;
  logic [N-1:0][DATA_W-1:0] data_q;
  logic [NQ-1:0][IDX_W-1:0] q_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_id_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_port
    always_comb begin
      q_hit_o[q] = 1'b0;
      q_idx[q]   = '0;
      for (int e = 0; e < N; e++) begin
        if (!q_hit_o[q] && valid_q[e] && tag_q[e] == q_id_i[q]) begin
          q_hit_o[q] = 1'b1;
          q_idx[q]   = IDX_W'(e);
        end
      end
    end
  end

  assign rd_idx_o  = q_idx[0];
  assign rd_data_o = data_q[q_idx[0]];
  assign valid_o   = valid_q;
endmodule

// File: rtl/tpb_lru.sv
module tpb_lru #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             a_en_i,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic             b_en_i,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  // ages form a permutation of 0..N-1; 0 is most recent
  logic [N-1:0][IDX_W-1:0] age_q, age_d;
  logic [IDX_W-1:0] ta, tb;
  logic free_found;

  always_comb begin
    age_d = age_q;
    ta = age_d[a_idx_i];
    if (a_en_i) begin
      for (int e = 0; e < N; e++)
        if (age_d[e] < ta) age_d[e] = age_d[e] + 1'b1;
      age_d[a_idx_i] = '0;
    end
    tb = age_d[b_idx_i];
    if (b_en_i) begin
      for (int e = 0; e < N; e++)
        if (age_d[e] < tb) age_d[e] = age_d[e] + 1'b1;
      age_d[b_idx_i] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N; e++) age_q[e] <= IDX_W'(e);
    end else begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim_o   = '0;
    free_found = 1'b0;
    for (int e = 0; e < N; e++) begin
      if (!free_found && !valid_i[e]) begin
        victim_o   = IDX_W'(e);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int e = 0; e < N; e++)
        if (age_q[e] == IDX_W'(N - 1)) victim_o = IDX_W'(e);
    end
  end
endmodule

// File: rtl/trace_pfb.sv
module trace_pfb
  import tpb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ID_W      = 16,
  parameter int DATA_W    = 32,
  parameter int CONF_W    = 3,
  parameter int STAT_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pf_valid_i,
  input  logic [ID_W-1:0]   pf_id_i,
  input  logic [CONF_W-1:0] pf_conf_i,
  input  logic              l1_hit_i,
  input  logic              l2_hit_i,
  output logic              l2_req_o,
  output logic [ID_W-1:0]   l2_req_id_o,
  input  logic              l2_rsp_valid_i,
  input  logic [DATA_W-1:0] l2_rsp_data_i,
  input  logic              dm_valid_i,
  input  logic [ID_W-1:0]   dm_id_i,
  output logic              dm_hit_o,
  output logic [DATA_W-1:0] dm_data_o,
  output logic [STAT_W-1:0] cnt_issue_o,
  output logic [STAT_W-1:0] cnt_hit_o,
  output logic [STAT_W-1:0] cnt_cancel_o,
  output logic [STAT_W-1:0] cnt_busy_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  logic                 busy_q;
  logic [ID_W-1:0]      fly_id_q;
  logic [2:0][ID_W-1:0] q_id;
  logic [2:0]           q_hit;
  logic [IDX_W-1:0]     dm_idx, victim;
  logic [DATA_W-1:0]    rd_data;
  logic [N_ENTRIES-1:0] ent_valid;
  logic                 dm_hit, install;
  pf_act_e              act;

  // port 0: demand, port 1: prefetch probe, port 2: duplicate guard
  assign q_id[0] = dm_id_i;
  assign q_id[1] = pf_id_i;
  assign q_id[2] = fly_id_q;

  tpb_store #(.N(N_ENTRIES), .ID_W(ID_W), .DATA_W(DATA_W), .NQ(3)) i_store (
    .clk_i, .rst_ni,
    .wr_en_i  (install),
    .wr_idx_i (victim),
    .wr_id_i  (fly_id_q),
    .wr_data_i(l2_rsp_data_i),
    .q_id_i   (q_id),
    .q_hit_o  (q_hit),
    .rd_idx_o (dm_idx),
    .rd_data_o(rd_data),
    .valid_o  (ent_valid)
  );

  tpb_lru #(.N(N_ENTRIES)) i_lru (
    .clk_i, .rst_ni,
    .valid_i (ent_valid),
    .a_en_i  (dm_hit),
    .a_idx_i (dm_idx),
    .b_en_i  (install),
    .b_idx_i (victim),
    .victim_o(victim)
  );

  always_comb begin
    act = PF_NONE;
    if (pf_valid_i && pf_conf_i != '0) begin
      if (l1_hit_i || q_hit[1]) act = PF_CANCEL;
      else if (busy_q)          act = PF_BUSY;
      else if (l2_hit_i)        act = PF_ISSUE;
    end
  end

  assign dm_hit  = dm_valid_i && q_hit[0];
  assign install = busy_q && l2_rsp_valid_i && !q_hit[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      fly_id_q <= '0;
    end else if (act == PF_ISSUE) begin
      busy_q   <= 1'b1;
      fly_id_q <= pf_id_i;
    end else if (busy_q && l2_rsp_valid_i) begin
      busy_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_issue_o  <= '0;
      cnt_hit_o    <= '0;
      cnt_cancel_o <= '0;
      cnt_busy_o   <= '0;
    end else begin
      if (act == PF_ISSUE)  cnt_issue_o  <= cnt_issue_o + 1'b1;
      if (act == PF_CANCEL) cnt_cancel_o <= cnt_cancel_o + 1'b1;
      if (act == PF_BUSY)   cnt_busy_o   <= cnt_busy_o + 1'b1;
      if (dm_hit)           cnt_hit_o    <= cnt_hit_o + 1'b1;
    end
  end

  assign l2_req_o    = (act == PF_ISSUE);
  assign l2_req_id_o = pf_id_i;
  assign dm_hit_o    = dm_hit;
  assign dm_data_o   = rd_data;
endmodule

// File: rtl/trace_pfb_chk.sv
module tpb_store_chk #(
  parameter int N    = 16,
  parameter int ID_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N-1:0]            valid_i,
  input logic [N-1:0][ID_W-1:0]  tags_i
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (valid_i[i] && valid_i[j] && tags_i[i] == tags_i[j]) dup = 1'b1;
  end

  // R6
  unique_tags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !dup);
endmodule

module trace_pfb_chk #(
  parameter int CONF_W = 3,
  parameter int STAT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pf_valid_i,
  input logic [CONF_W-1:0] pf_conf_i,
  input logic              l1_hit_i,
  input logic              l2_hit_i,
  input logic              l2_req_i,
  input logic              busy_i,
  input logic              rsp_valid_i,
  input logic              dm_valid_i,
  input logic              dm_hit_i,
  input logic [STAT_W-1:0] cnt_issue_i,
  input logic [STAT_W-1:0] cnt_cancel_i,
  input logic [STAT_W-1:0] cnt_busy_i
);
  // R2
  zero_conf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_i && pf_conf_i == '0) |-> !l2_req_i);

  // R2
  idle_counters_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pf_valid_i && pf_conf_i != '0) |=>
      ($stable(cnt_issue_i) && $stable(cnt_cancel_i) && $stable(cnt_busy_i)));

  // R4
  req_needs_l2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_i |-> (l2_hit_i && !l1_hit_i));

  // R5
  single_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_i |-> !busy_i);

  // R5
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rsp_valid_i) |=> busy_i);

  // R7
  no_spurious_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dm_valid_i |-> !dm_hit_i);
endmodule

bind tpb_store tpb_store_chk #(.N(N), .ID_W(ID_W)) i_store_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_q), .tags_i(tag_q)
);

bind trace_pfb trace_pfb_chk #(.CONF_W(CONF_W), .STAT_W(STAT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pf_valid_i(pf_valid_i), .pf_conf_i(pf_conf_i),
  .l1_hit_i(l1_hit_i), .l2_hit_i(l2_hit_i), .l2_req_i(l2_req_o), .busy_i(busy_q),
  .rsp_valid_i(l2_rsp_valid_i), .dm_valid_i(dm_valid_i), .dm_hit_i(dm_hit_o),
  .cnt_issue_i(cnt_issue_o), .cnt_cancel_i(cnt_cancel_o), .cnt_busy_i(cnt_busy_o)
);

// File: tb/test_trace_pfb.sv
`timescale 1ns/1ps
module test_trace_pfb;
  localparam int N = 16, ID_W = 16, DATA_W = 32, CONF_W = 3, STAT_W = 16, L2_LAT = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic pf_valid_i = 0, l1_hit_i = 0, l2_hit_i = 0, l2_rsp_valid_i = 0, dm_valid_i = 0;
  logic [ID_W-1:0] pf_id_i = 0, dm_id_i = 0;
  logic [CONF_W-1:0] pf_conf_i = 0;
  logic [DATA_W-1:0] l2_rsp_data_i = 0;
  logic l2_req_o, dm_hit_o;
  logic [ID_W-1:0] l2_req_id_o;
  logic [DATA_W-1:0] dm_data_o;
  logic [STAT_W-1:0] cnt_issue_o, cnt_hit_o, cnt_cancel_o, cnt_busy_o;

  trace_pfb #(.N_ENTRIES(N), .ID_W(ID_W), .DATA_W(DATA_W), .CONF_W(CONF_W), .STAT_W(STAT_W))
  i_trace_pfb (
    .clk_i(clk), .rst_ni, .pf_valid_i, .pf_id_i, .pf_conf_i, .l1_hit_i, .l2_hit_i,
    .l2_req_o, .l2_req_id_o, .l2_rsp_valid_i, .l2_rsp_data_i, .dm_valid_i, .dm_id_i,
    .dm_hit_o, .dm_data_o, .cnt_issue_o, .cnt_hit_o, .cnt_cancel_o, .cnt_busy_o
  );

  int n_chk = 0, n_fail = 0, cyc = 0, rsp_at = 0;
  int c_iss = 0, c_hit = 0, c_can = 0, c_bsy = 0;
  bit busy_m = 0, done = 0;
  logic [ID_W-1:0] fly_m = 0;
  logic [ID_W-1:0] lru_q[$];  // front = most recent

  function automatic logic [DATA_W-1:0] dat(logic [ID_W-1:0] id);
    return {id, id ^ 16'hA5A5};
  endfunction
  function automatic bit in_l1(logic [ID_W-1:0] id);
    return id[15:12] == 4'hE;
  endfunction
  function automatic bit in_l2(logic [ID_W-1:0] id);
    return id[15:12] != 4'hF;
  endfunction
  function automatic int find(logic [ID_W-1:0] id);
    for (int i = 0; i < lru_q.size(); i++) if (lru_q[i] == id) return i;
    return -1;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit pv, logic [ID_W-1:0] pid, logic [CONF_W-1:0] pc,
                      bit dv, logic [ID_W-1:0] did, string dtag, bit spur = 0);
    int a; bit rv, eh, full; string ltag; logic [ID_W-1:0] vic;
    @(negedge clk);
    pf_valid_i = pv; pf_id_i = pid; pf_conf_i = pc;
    l1_hit_i = in_l1(pid); l2_hit_i = in_l2(pid);
    dm_valid_i = dv; dm_id_i = did;
    rv = (busy_m && cyc == rsp_at) || spur;
    l2_rsp_valid_i = rv; l2_rsp_data_i = dat(fly_m);
    #1;
    a = 0; ltag = "R4";
    if (pv && pc == 0) ltag = "R2";
    else if (pv) begin
      if (in_l1(pid) || find(pid) >= 0) a = 1;
      else if (busy_m) a = 2;
      else if (in_l2(pid)) a = 3;
      else ltag = "R10";
    end
    chk(ltag, "l2_req", l2_req_o, a == 3);
    if (a == 3) chk("R4", "l2_req_id", l2_req_id_o, pid);
    eh = dv && find(did) >= 0;
    chk(dtag, "dm_hit", dm_hit_o, eh);
    if (eh) chk(dtag, "dm_data", dm_data_o, dat(did));
    chk("R4", "cnt_issue", cnt_issue_o, c_iss);
    chk("R7", "cnt_hit", cnt_hit_o, c_hit);
    chk("R3", "cnt_cancel", cnt_cancel_o, c_can);
    chk("R5", "cnt_busy", cnt_busy_o, c_bsy);
    @(posedge clk);
    full = lru_q.size() == N;
    vic = full ? lru_q[$] : '0;
    if (eh) begin
      lru_q.delete(find(did));
      lru_q.push_front(did);
      c_hit++;
    end
    if (busy_m && rv) begin
      busy_m = 0;
      if (find(fly_m) < 0) begin
        if (full) lru_q.delete(find(vic));
        lru_q.push_front(fly_m);
      end
    end
    case (a)
      1: c_can++;
      2: c_bsy++;
      3: begin c_iss++; busy_m = 1; fly_m = pid; rsp_at = cyc + L2_LAT; end
      default: ;
    endcase
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "R7");
  endtask

  // request, wait, and optionally look up dm_id in the response cycle
  task automatic pf_run(logic [ID_W-1:0] id, bit dv, logic [ID_W-1:0] did, string tag);
    step(1, id, 3'd2, 0, 0, "R7");
    idle(L2_LAT - 1);
    step(0, 0, 0, dv, did, tag);
  endtask

  task automatic look(logic [ID_W-1:0] id, string tag);
    step(0, 0, 0, 1, id, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "cnt_issue", cnt_issue_o, 0);
    chk("R1", "cnt_hit", cnt_hit_o, 0);
    chk("R1", "cnt_cancel", cnt_cancel_o, 0);
    chk("R1", "cnt_busy", cnt_busy_o, 0);
    chk("R1", "l2_req", l2_req_o, 0);
    look(16'h0000, "R1"); look(16'h0001, "R1");

    // R2 zero confidence
    step(1, 16'h0001, 3'd0, 0, 0, "R2"); idle(2);
    // R10 absent everywhere
    step(1, 16'hF001, 3'd7, 0, 0, "R10"); idle(2);
    // R3 present in first-level cache
    step(1, 16'hE001, 3'd1, 0, 0, "R3");
    // R4 issue, R5 drops during flight and in the response cycle
    step(1, 16'h0001, 3'd1, 0, 0, "R7");
    step(1, 16'h0002, 3'd4, 0, 0, "R5");
    idle(L2_LAT - 2);
    step(1, 16'h0003, 3'd4, 0, 0, "R5");
    look(16'h0001, "R6");
    // R3 cancel on buffer hit, even while idle
    step(1, 16'h0001, 3'd5, 0, 0, "R3");
    // R11 response while idle is ignored
    step(0, 0, 0, 0, 0, "R11", 1);
    look(16'h0000, "R11"); look(16'h0002, "R11");
    chk("R11", "cnt_issue", cnt_issue_o, 1);

    // R8 fill the buffer
    for (int k = 0; k < N - 1; k++) pf_run(16'h0100 + 16'(k), 0, 0, "R8");
    look(16'h0001, "R8");           // oldest becomes most recent
    pf_run(16'h0200, 0, 0, "R8");   // evicts 0x0100
    look(16'h0100, "R8"); look(16'h0001, "R8"); look(16'h0200, "R8");

    // R9 demand hit on the victim in the response cycle
    pf_run(16'h0300, 1, 16'h0101, "R9");
    look(16'h0101, "R9"); look(16'h0300, "R9");
    look(16'h0102, "R9");           // refresh 0x0102
    pf_run(16'h0301, 1, 16'h0103, "R9");  // victim 0x0103 hit then replaced
    look(16'h0103, "R9"); look(16'h0301, "R9"); look(16'h0102, "R9");

    // random mix over a pool wider than the buffer
    for (int i = 0; i < 4000; i++) begin
      logic [ID_W-1:0] p, d; int r;
      r = $urandom_range(0, 9);
      p = {(r < 7) ? 4'h0 : (r < 9 ? 4'hE : 4'hF), 7'd0, 5'($urandom_range(0, 23))};
      d = {4'h0, 7'd0, 5'($urandom_range(0, 23))};
      step($urandom_range(0, 2) == 0, p, 3'($urandom_range(0, 7)),
           $urandom_range(0, 1) == 1, d, "R9", $urandom_range(0, 49) == 0);
    end
    idle(L2_LAT + 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule